// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This controller-side block brings a synchronous DRAM from reset to an operational state. It drives the clock-enable, data-mask and command/address pins of the memory through the start-up sequence. First comes a long stretch of idle commands. Then one precharge that closes every bank, a programmable number of auto-refresh commands and one mode register load. After the last command's recovery time has passed, it raises a ready flag. Normal-operation logic takes the command bus from that point on.

The idle stretch is counted in clock cycles. The count is derived from the clock frequency (in kHz) and a minimum time in microseconds, and is rounded up. The recovery times after a precharge, a refresh and a mode load are given as cycle counts. A parameter picks whether the refresh burst or the mode load comes first. A synchronous reset restarts the whole sequence at any moment.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset onward, on every cycle, sd_cke is 1 and every bit of sd_dqm is 1. While rst is high, and in cycles 1..W after its release, the pins carry the idle command: sd_cs_n=0, sd_ras_n=1, sd_cas_n=1, sd_we_n=1.
- R2: The idle stretch is W = ceil(WAIT_US*CLK_KHZ/1000) cycles. The first non-idle command appears in cycle W+1, where cycle 1 is the first clock edge with rst low.
- R3: The first command is a precharge of all banks: sd_ras_n=0, sd_cas_n=1, sd_we_n=0, with sd_addr[10]=1.
- R4: Exactly max(NUM_REFRESH,2) auto-refresh commands are issued: sd_ras_n=0, sd_cas_n=0, sd_we_n=1.
- R5: Exactly one mode register load is issued. All four command lines are low, sd_addr equals MODE_VALUE and sd_ba equals 0.
- R6: With MRS_FIRST=0 the order is precharge, refreshes, mode load. With MRS_FIRST=1 it is precharge, mode load, refreshes.
- R7: Each command follows the previous one by exactly the recovery count of the previous command's kind: max(T_RP,1) after a precharge, max(T_RFC,1) after a refresh, max(T_MRD,1) after a mode load.
- R8: init_done rises exactly one recovery count after the last command, following the rule of R7. It then stays high until reset, and no further non-idle command is issued.
- R9: Raising rst at any point gives, after the next edge, init_done=0 and idle pins. After rst is released, the whole sequence repeats with the timing of R2 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_dqm | output | DQM_W | Data mask lines, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ROW_W | Address pins; bit 10 selects all banks on precharge |
| init_done | output | 1 | High once initialization has completed |

## Verification
The hardest situation to reach is a reset that lands partway through the command phase. The clean case is a reset between the precharge and the first refresh, where a leftover refresh count or a partly expired timer would shift every later command. The bench counts cycles from each reset release. It raises reset on a chosen cycle just after the precharge and checks the pins one edge later. It then re-times the complete rerun against a schedule computed from the parameters. A second instance uses the opposite phase order, a refresh count below the floor and a one-cycle precharge recovery, so that the clamping rules are also exercised.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command placed on the memory pins in a given cycle
  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_PRECHARGE_ALL,
    CMD_AUTO_REFRESH,
    CMD_LOAD_MODE
  } sd_cmd_e;

  // Action waiting for the countdown to expire
  typedef enum logic [2:0] {
    ACT_PRECHARGE,
    ACT_REFRESH,
    ACT_LOAD_MODE,
    ACT_SIGNAL_DONE,
    ACT_HALT
  } init_act_e;

  function automatic int unsigned floor_at(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int unsigned idle_cycles(input int unsigned wait_us, input int unsigned clk_khz);
    return (wait_us * clk_khz + 999) / 1000;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counter: reloaded on request, reports when it has reached zero.
module sdram_init_timer #(
  parameter int unsigned  CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_pins.sv
// Registered pin driver: turns a command code into the memory pin levels.
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int unsigned      ROW_W       = 12,
  parameter int unsigned      BA_W        = 2,
  parameter int unsigned      DQM_W       = 1,
  parameter int unsigned      ALL_BANK_BIT = 10,
  parameter logic [ROW_W-1:0] MODE_VALUE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  sd_cmd_e          cmd,
  output logic             cke,
  output logic [DQM_W-1:0] dqm,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);

  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << ALL_BANK_BIT;

  // Clock enable and mask stay high for the whole initialization
  always_ff @(posedge clk) begin
    cke <= 1'b1;
    dqm <= '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
    end else begin
      cs_n <= 1'b0;
      ba   <= '0;
      case (cmd)
        CMD_PRECHARGE_ALL: begin
          ras_n <= 1'b0; cas_n <= 1'b1; we_n <= 1'b0;
          addr  <= ALL_BANKS;
        end
        CMD_AUTO_REFRESH: begin
          ras_n <= 1'b0; cas_n <= 1'b0; we_n <= 1'b1;
          addr  <= '0;
        end
        CMD_LOAD_MODE: begin
          ras_n <= 1'b0; cas_n <= 1'b0; we_n <= 1'b0;
          addr  <= MODE_VALUE;
        end
        default: begin
          ras_n <= 1'b1; cas_n <= 1'b1; we_n <= 1'b1;
          addr  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
// Power-up sequencer: idle stretch, precharge-all, refresh burst and mode
// load in a parameter-selected order, then a sticky done flag.
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned      CLK_KHZ     = 250000,
  parameter int unsigned      WAIT_US     = 200,
  parameter int unsigned      T_RP        = 3,
  parameter int unsigned      T_RFC       = 9,
  parameter int unsigned      T_MRD       = 2,
  parameter int unsigned      NUM_REFRESH = 2,
  parameter bit               MRS_FIRST   = 1'b0,
  parameter int unsigned      ROW_W       = 12,
  parameter int unsigned      BA_W        = 2,
  parameter int unsigned      DQM_W       = 1,
  parameter logic [ROW_W-1:0] MODE_VALUE  = 12'h033
) (
  input  logic             clk,
  input  logic             rst,
  output logic             sd_cke,
  output logic [DQM_W-1:0] sd_dqm,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic             init_done
);

  localparam int unsigned IDLE_CYC = idle_cycles(WAIT_US, CLK_KHZ);
  localparam int unsigned RP       = floor_at(T_RP, 1);
  localparam int unsigned RFC      = floor_at(T_RFC, 1);
  localparam int unsigned MRD      = floor_at(T_MRD, 1);
  localparam int unsigned NREF     = floor_at(NUM_REFRESH, 2);
  localparam int unsigned MAX_CNT  = floor_at(IDLE_CYC, max3(RP, RFC, MRD));
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);
  localparam int unsigned REF_W    = $clog2(NREF + 1);

  // Phase order chosen by parameter
  localparam init_act_e AFTER_PRE = MRS_FIRST ? ACT_LOAD_MODE   : ACT_REFRESH;
  localparam init_act_e AFTER_REF = MRS_FIRST ? ACT_SIGNAL_DONE : ACT_LOAD_MODE;
  localparam init_act_e AFTER_MRS = MRS_FIRST ? ACT_REFRESH     : ACT_SIGNAL_DONE;

  init_act_e        pending_q, pending_d;
  logic [REF_W-1:0] refs_left_q;
  logic             done_q;
  logic             expired;
  logic             fire;
  logic             load;
  logic [CNT_W-1:0] load_val;
  sd_cmd_e          cmd;

  assign fire = expired && (pending_q != ACT_HALT);

  always_comb begin
    pending_d = pending_q;
    load      = 1'b0;
    load_val  = '0;
    cmd       = CMD_IDLE;
    if (fire) begin
      case (pending_q)
        ACT_PRECHARGE: begin
          cmd       = CMD_PRECHARGE_ALL;
          load      = 1'b1;
          load_val  = CNT_W'(RP - 1);
          pending_d = AFTER_PRE;
        end
        ACT_REFRESH: begin
          cmd       = CMD_AUTO_REFRESH;
          load      = 1'b1;
          load_val  = CNT_W'(RFC - 1);
          pending_d = (refs_left_q == REF_W'(1)) ? AFTER_REF : ACT_REFRESH;
        end
        ACT_LOAD_MODE: begin
          cmd       = CMD_LOAD_MODE;
          load      = 1'b1;
          load_val  = CNT_W'(MRD - 1);
          pending_d = AFTER_MRS;
        end
        ACT_SIGNAL_DONE: begin
          pending_d = ACT_HALT;
        end
        default: pending_d = ACT_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= ACT_PRECHARGE;
      refs_left_q <= REF_W'(NREF);
      done_q      <= 1'b0;
    end else begin
      pending_q <= pending_d;
      if (fire && pending_q == ACT_REFRESH) begin
        refs_left_q <= refs_left_q - 1'b1;
      end
      if (fire && pending_q == ACT_SIGNAL_DONE) begin
        done_q <= 1'b1;
      end
    end
  end

  assign init_done = done_q;

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (CNT_W'(IDLE_CYC))
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_init_pins #(
    .ROW_W        (ROW_W),
    .BA_W         (BA_W),
    .DQM_W        (DQM_W),
    .ALL_BANK_BIT (10),
    .MODE_VALUE   (MODE_VALUE)
  ) u_pins (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .cke   (sd_cke),
    .dqm   (sd_dqm),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ba    (sd_ba),
    .addr  (sd_addr)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int unsigned      CLK_KHZ    = 250000,
  parameter int unsigned      WAIT_US    = 200,
  parameter int unsigned      T_RP       = 3,
  parameter int unsigned      T_RFC      = 9,
  parameter int unsigned      T_MRD      = 2,
  parameter int unsigned      ROW_W      = 12,
  parameter int unsigned      BA_W       = 2,
  parameter int unsigned      DQM_W      = 1,
  parameter logic [ROW_W-1:0] MODE_VALUE = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             sd_cke,
  input logic [DQM_W-1:0] sd_dqm,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr,
  input logic             init_done
);

  localparam int unsigned IDLE_CYC = idle_cycles(WAIT_US, CLK_KHZ);
  localparam int unsigned RP       = floor_at(T_RP, 1);
  localparam int unsigned RFC      = floor_at(T_RFC, 1);
  localparam int unsigned MRD      = floor_at(T_MRD, 1);
  localparam int unsigned SINCE_W  = $clog2(IDLE_CYC + 3);
  localparam int unsigned GAP_MAX  = max3(RP, RFC, MRD) + 1;
  localparam int unsigned GAP_W    = $clog2(GAP_MAX + 1);

  logic is_idle, is_pre, is_ref, is_mrs, is_cmd;
  assign is_idle = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
  assign is_pre  = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
  assign is_ref  = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;
  assign is_mrs  = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
  assign is_cmd  = !is_idle;

  logic [SINCE_W-1:0] since_q;
  logic [GAP_W-1:0]   gap_q;
  logic [GAP_W-1:0]   need_q;
  logic               have_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q     <= '0;
      gap_q       <= '0;
      need_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      if (since_q != SINCE_W'(IDLE_CYC + 2)) since_q <= since_q + 1'b1;
      if (is_cmd) begin
        gap_q       <= GAP_W'(1);
        have_prev_q <= 1'b1;
        need_q      <= is_pre ? GAP_W'(RP) : (is_ref ? GAP_W'(RFC) : GAP_W'(MRD));
      end else if (gap_q != GAP_W'(GAP_MAX)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_cke_dqm_high_r1: assert property (@(posedge clk) disable iff (rst)
    sd_cke && (&sd_dqm));

  p_idle_during_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (since_q <= SINCE_W'(IDLE_CYC)) |-> is_idle);

  p_first_is_precharge_all_r3: assert property (@(posedge clk) disable iff (rst)
    (since_q == SINCE_W'(IDLE_CYC + 1)) |-> (is_pre && sd_addr[10]));

  p_mode_fields_r5: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (sd_addr == MODE_VALUE && sd_ba == '0));

  p_command_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && have_prev_q) |-> (gap_q == need_q));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_idle);

  p_done_after_recovery_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (have_prev_q && gap_q == need_q));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .CLK_KHZ    (CLK_KHZ),
  .WAIT_US    (WAIT_US),
  .T_RP       (T_RP),
  .T_RFC      (T_RFC),
  .T_MRD      (T_MRD),
  .ROW_W      (ROW_W),
  .BA_W       (BA_W),
  .DQM_W      (DQM_W),
  .MODE_VALUE (MODE_VALUE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps

// Pin monitor: numbers cycles from reset release and logs every command.
module sdram_init_mon #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned DQM_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic [DQM_W-1:0] dqm,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic             ready
);
  int   cyc, nev, ready_cyc, bad_pins, ready_drops, late_cmds;
  int   ev_kind[16];
  int   ev_cyc[16];
  int   ev_addr[16];
  int   ev_ba[16];
  logic rst_q = 1'b1;

  always @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    int kind;
    if (!cke || dqm != '1) bad_pins++;
    if (rst_q) begin
      cyc = 0; nev = 0; ready_cyc = 0; ready_drops = 0; late_cmds = 0;
    end else begin
      cyc++;
      if (cs_n) kind = 4;
      else if (ras_n && cas_n && we_n) kind = 0;
      else if (!ras_n && cas_n && !we_n) kind = 1;
      else if (!ras_n && !cas_n && we_n) kind = 2;
      else if (!ras_n && !cas_n && !we_n) kind = 3;
      else kind = 4;
      if (kind != 0) begin
        if (nev < 16) begin
          ev_kind[nev] = kind; ev_cyc[nev] = cyc;
          ev_addr[nev] = int'(addr); ev_ba[nev] = int'(ba);
        end
        nev++;
        if (ready_cyc != 0) late_cmds++;
      end
      if (ready && ready_cyc == 0) ready_cyc = cyc;
      if (!ready && ready_cyc != 0) ready_drops++;
    end
  end
endmodule

module sdram_init_seq_bench;
  localparam int ROW_W = 12, BA_W = 2, DQM_W = 2;
  // instance A: refreshes before mode load
  localparam int A_KHZ = 250000, A_US = 2, A_RP = 3, A_RFC = 7, A_MRD = 2, A_NREF = 3;
  localparam logic [11:0] A_MODE = 12'h033;
  // instance B: mode load first, clamped refresh count and precharge spacing
  localparam int B_KHZ = 250000, B_US = 1, B_RP = 0, B_RFC = 4, B_MRD = 5, B_NREF = 1;
  localparam logic [11:0] B_MODE = 12'h6A7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;

  logic             a_cke, a_cs_n, a_ras_n, a_cas_n, a_we_n, a_done;
  logic [DQM_W-1:0] a_dqm;
  logic [BA_W-1:0]  a_ba;
  logic [ROW_W-1:0] a_addr;
  logic             b_cke, b_cs_n, b_ras_n, b_cas_n, b_we_n, b_done;
  logic [DQM_W-1:0] b_dqm;
  logic [BA_W-1:0]  b_ba;
  logic [ROW_W-1:0] b_addr;

  sdram_init_seq #(.CLK_KHZ(A_KHZ), .WAIT_US(A_US), .T_RP(A_RP), .T_RFC(A_RFC),
    .T_MRD(A_MRD), .NUM_REFRESH(A_NREF), .MRS_FIRST(1'b0), .ROW_W(ROW_W),
    .BA_W(BA_W), .DQM_W(DQM_W), .MODE_VALUE(A_MODE)) u_sdram_init_seq (
    .clk(clk), .rst(rst), .sd_cke(a_cke), .sd_dqm(a_dqm), .sd_cs_n(a_cs_n),
    .sd_ras_n(a_ras_n), .sd_cas_n(a_cas_n), .sd_we_n(a_we_n), .sd_ba(a_ba),
    .sd_addr(a_addr), .init_done(a_done));

  sdram_init_seq #(.CLK_KHZ(B_KHZ), .WAIT_US(B_US), .T_RP(B_RP), .T_RFC(B_RFC),
    .T_MRD(B_MRD), .NUM_REFRESH(B_NREF), .MRS_FIRST(1'b1), .ROW_W(ROW_W),
    .BA_W(BA_W), .DQM_W(DQM_W), .MODE_VALUE(B_MODE)) u_sdram_init_seq_alt (
    .clk(clk), .rst(rst), .sd_cke(b_cke), .sd_dqm(b_dqm), .sd_cs_n(b_cs_n),
    .sd_ras_n(b_ras_n), .sd_cas_n(b_cas_n), .sd_we_n(b_we_n), .sd_ba(b_ba),
    .sd_addr(b_addr), .init_done(b_done));

  sdram_init_mon #(.ROW_W(ROW_W), .BA_W(BA_W), .DQM_W(DQM_W)) u_mon_a (
    .clk(clk), .rst(rst), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs_n), .ras_n(a_ras_n),
    .cas_n(a_cas_n), .we_n(a_we_n), .ba(a_ba), .addr(a_addr), .ready(a_done));
  sdram_init_mon #(.ROW_W(ROW_W), .BA_W(BA_W), .DQM_W(DQM_W)) u_mon_b (
    .clk(clk), .rst(rst), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs_n), .ras_n(b_ras_n),
    .cas_n(b_cas_n), .we_n(b_we_n), .ba(b_ba), .addr(b_addr), .ready(b_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap_of(input int kind, input int rp, input int rfc, input int mrd);
    int t;
    t = (kind == 1) ? rp : ((kind == 2) ? rfc : mrd);
    return (t < 1) ? 1 : t;
  endfunction

  // Pins of both instances while reset is held (R1, R9)
  task automatic check_reset_pins(input string tag);
    chk(a_cke && a_dqm == '1 && b_cke && b_dqm == '1, {tag, " R1 cke/dqm high in reset"},
        int'({a_cke, b_cke}), 3);
    chk(!a_cs_n && a_ras_n && a_cas_n && a_we_n && !b_cs_n && b_ras_n && b_cas_n && b_we_n,
        {tag, " R1 idle pins in reset"}, int'({a_ras_n, a_cas_n, a_we_n}), 7);
    chk(!a_done && !b_done, {tag, " R9 done low in reset"}, int'({a_done, b_done}), 0);
  endtask

  // Compare one instance's logged run against a schedule computed from its parameters
  task automatic check_run(input int which, input string tag);
    int kind[16], cy[16], ad[16], bk[16];
    int nev, rdy, bad, drops, late;
    int khz, us, rp, rfc, mrd, nref, w, n, rdy_exp, mode;
    bit mfirst;
    int ek[16], ec[16];
    if (which == 0) begin
      kind = u_mon_a.ev_kind; cy = u_mon_a.ev_cyc; ad = u_mon_a.ev_addr; bk = u_mon_a.ev_ba;
      nev = u_mon_a.nev; rdy = u_mon_a.ready_cyc; bad = u_mon_a.bad_pins;
      drops = u_mon_a.ready_drops; late = u_mon_a.late_cmds;
      khz = A_KHZ; us = A_US; rp = A_RP; rfc = A_RFC; mrd = A_MRD; nref = A_NREF;
      mfirst = 1'b0; mode = int'(A_MODE);
    end else begin
      kind = u_mon_b.ev_kind; cy = u_mon_b.ev_cyc; ad = u_mon_b.ev_addr; bk = u_mon_b.ev_ba;
      nev = u_mon_b.nev; rdy = u_mon_b.ready_cyc; bad = u_mon_b.bad_pins;
      drops = u_mon_b.ready_drops; late = u_mon_b.late_cmds;
      khz = B_KHZ; us = B_US; rp = B_RP; rfc = B_RFC; mrd = B_MRD; nref = B_NREF;
      mfirst = 1'b1; mode = int'(B_MODE);
    end
    if (nref < 2) nref = 2;
    w = (us * khz + 999) / 1000;
    n = 0;
    ek[n++] = 1;
    if (mfirst) ek[n++] = 3;
    for (int i = 0; i < nref; i++) ek[n++] = 2;
    if (!mfirst) ek[n++] = 3;
    ec[0] = w + 1;
    for (int i = 1; i < n; i++) ec[i] = ec[i-1] + gap_of(ek[i-1], rp, rfc, mrd);
    rdy_exp = ec[n-1] + gap_of(ek[n-1], rp, rfc, mrd);

    chk(bad == 0, {tag, " R1 cke/dqm never low"}, bad, 0);
    chk(nev == n, {tag, " R4 command count"}, nev, n);
    chk(cy[0] == w + 1, {tag, " R2 first command cycle"}, cy[0], w + 1);
    chk(kind[0] == 1 && ad[0][10], {tag, " R3 precharge all first"}, kind[0], 1);
    for (int i = 1; i < n && i < nev; i++) begin
      chk(kind[i] == ek[i], $sformatf("%s R6 kind of command %0d", tag, i), kind[i], ek[i]);
      chk(cy[i] == ec[i], $sformatf("%s R7 cycle of command %0d", tag, i), cy[i], ec[i]);
      if (ek[i] == 3) begin
        chk(ad[i] == mode, {tag, " R5 mode value on address"}, ad[i], mode);
        chk(bk[i] == 0, {tag, " R5 bank zero on mode load"}, bk[i], 0);
      end
    end
    chk(rdy == rdy_exp, {tag, " R8 done rise cycle"}, rdy, rdy_exp);
    chk(drops == 0, {tag, " R8 done stays high"}, drops, 0);
    chk(late == 0, {tag, " R8 no command after done"}, late, 0);
  endtask

  task automatic hold_reset(input int cycles);
    @(posedge clk); #1 rst = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic t_power_up();
    hold_reset(4);
    check_reset_pins("power-up");
    release_reset();
    repeat (700) @(negedge clk);
    check_run(0, "run1 A");
    check_run(1, "run1 B");
  endtask

  task automatic t_reset_mid_sequence();
    // restart, then hit reset one cycle after instance A's precharge (R9)
    hold_reset(2);
    release_reset();
    while (u_mon_a.cyc != 502) @(negedge clk);
    chk(u_mon_a.nev == 1, "R9 precharge seen before mid reset", u_mon_a.nev, 1);
    hold_reset(1);
    check_reset_pins("mid-reset");
    release_reset();
    repeat (700) @(negedge clk);
    check_run(0, "R9 rerun A");
    check_run(1, "R9 rerun B");
  endtask

  task automatic t_reset_after_done();
    chk(a_done && b_done, "R8 done high before reset", int'({a_done, b_done}), 3);
    hold_reset(1);
    check_reset_pins("post-done");
    release_reset();
    repeat (700) @(negedge clk);
    check_run(0, "R9 third A");
    check_run(1, "R9 third B");
  endtask

  initial begin
    t_power_up();
    t_reset_mid_sequence();
    t_reset_after_done();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule